// File: doc/BRIEF.md
# PWM Output Emergency Shutdown Controller

This block sits between a four-channel PWM generator and the output pads. While the channels run normally, each pad carries its PWM waveform with the driver enabled. An active-low external fault input is brought into the clock domain by a two-flop synchronizer and can then go through an optional noise filter. If shutdown is armed and the filtered fault is low, every channel is removed from the pads within two clock edges. Each pad then takes a fallback state set per channel: released (high impedance), driven low or driven high.

The trip sets a sticky disable bit on every channel. Once the fault line has gone high again, software clears those bits with a register write. A clear is refused while the fault is still present. A separate interrupt-request flag records level changes of the filtered fault in a chosen direction, whether or not shutdown is armed.

Software reaches the block through a single-cycle write port and a combinational read port with four word addresses.

Top module: `pwm_trip_guard`

## Requirements
- R1: A channel whose disable bit is 0, with no trip in progress, drives `pin_dat` equal to its `pwm_in` bit and `pin_oe` equal to 1.
- R2: Address 0 holds the disable bits in bits 3:0 (bit 0 is channel A, bit 3 is channel D) and the shutdown-arm bit in bit 7. Writing 1 to a disable bit disables that channel. After reset the disable bits read 1 and the arm bit reads 0, so address 0 reads 0x0F.
- R3: When the arm bit is 1 and the filtered fault is low, all four disable bits become 1 at the next clock edge.
- R4: With the filter bypassed and the block armed, a low on `fault_n` sampled at one rising edge puts every pad in its fallback state after the second rising edge. After the first edge the pads still carry PWM.
- R5: The disable bits stay 1 after the fault returns high. A write of 0 to a disable bit then clears it.
- R6: A write to address 0 has no effect on the disable bits while the block is armed and the filtered fault is low. Reading address 0 afterwards still shows 1 in bits 3:0.
- R7: Address 2 holds a 2-bit fallback code per channel in bits 2i+1:2i. Code 00 and code 11 give oe=0 and dat=0. Code 01 gives oe=1 and dat=0. Code 10 gives oe=1 and dat=1. After reset every code is 00.
- R8: Address 1 bits 1:0 select the filter. Code 00 bypasses it, and the sample history is preloaded with the synchronized level. Codes 01, 10 and 11 sample the synchronized level on prescaler ticks: every clock, every 8th clock or every 32nd clock of a 5-bit counter that runs freely from reset. The filtered level changes only when three consecutive samples agree, so a low pulse of two clocks at code 01 causes no trip.
- R9: Address 1 bit 2 sets the interrupt polarity: 0 means a falling edge of the filtered level, 1 means a rising edge. A matching change sets `irq`, which reads back at address 3 bit 0. Writing 0 to that bit clears `irq`. If a set and a clear fall in the same cycle, the set wins.
- R10: While the arm bit is 0, the fault input changes neither the disable bits nor the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 4 | PWM waveform per channel from the timer |
| fault_n | input | 1 | Asynchronous active-low fault input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pin_dat | output | 4 | Pad data per channel |
| pin_oe | output | 4 | Pad output enable per channel |
| irq | output | 1 | Interrupt-request flag |

## Verification
Two pairs of events can fall in the same clock. The first is a software write that clears the disable bits arriving while the fault trip is setting them. The second is a write that clears the interrupt flag arriving on the same edge as a new polarity-matching fault edge. The bench provokes both on purpose: a directed write lands while the fault is held low, and a random phase interleaves fault toggles with writes to every address. A cycle model of the rules above judges each cycle, expecting the disable bits to read back as all ones and the set to win over the clear.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_FILT = 2'd1;
    localparam logic [ADDR_W-1:0] REG_SAFE = 2'd2;
    localparam logic [ADDR_W-1:0] REG_STAT = 2'd3;

    typedef enum logic [1:0] {
        SAFE_FLOAT  = 2'b00,
        SAFE_LOW    = 2'b01,
        SAFE_HIGH   = 2'b10,
        SAFE_FLOAT2 = 2'b11
    } safe_e;

    typedef enum logic [1:0] {
        FLT_BYPASS = 2'b00,
        FLT_DIV1   = 2'b01,
        FLT_DIVMID = 2'b10,
        FLT_DIVMAX = 2'b11
    } flt_sel_e;

endpackage

// File: rtl/pwm_trip_filter.sv
module pwm_trip_filter
    import pwm_trip_pkg::*;
#(
    parameter int PRE_W   = 5,
    parameter int DIV_MID = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_n,
    input  logic [1:0] fsel,
    output logic       flt_o
);
    localparam int MID_W = $clog2(DIV_MID);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic [1:0]       hist;
        logic             flt;
        logic [PRE_W-1:0] cnt;
    } filt_st_t;

    filt_st_t q, d;
    logic     tick;

    always_comb begin
        d      = q;
        d.s1   = fault_n;
        d.s2   = q.s1;
        d.cnt  = q.cnt + 1'b1;
        unique case (flt_sel_e'(fsel))
            FLT_DIV1:   tick = 1'b1;
            FLT_DIVMID: tick = &q.cnt[MID_W-1:0];
            FLT_DIVMAX: tick = &q.cnt;
            default:    tick = 1'b0;
        endcase
        if (flt_sel_e'(fsel) == FLT_BYPASS) begin
            d.flt  = q.s2;
            d.hist = {2{q.s2}};
        end else if (tick) begin
            d.hist = {q.hist[0], q.s2};
            if (q.s2 == q.hist[0] && q.s2 == q.hist[1]) begin
                d.flt = q.s2;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: 1'b1, s2: 1'b1, hist: 2'b11, flt: 1'b1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign flt_o = (flt_sel_e'(fsel) == FLT_BYPASS) ? q.s2 : q.flt;

    // R8: the held level only moves to a value the synchronizer presented
    a_r8_change_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.flt) |-> (q.flt == $past(q.s2)));

endmodule

// File: rtl/pwm_trip_regs.sv
module pwm_trip_regs
    import pwm_trip_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              flt,
    output logic [NCH-1:0]    dis,
    output logic              trip,
    output logic [1:0]        fsel,
    output logic [2*NCH-1:0]  safe,
    output logic              irq
);
    localparam int SAFE_W = 2 * NCH;

    typedef struct packed {
        logic [NCH-1:0]    dis;
        logic              en;
        logic [1:0]        fsel;
        logic              pol;
        logic [SAFE_W-1:0] safe;
        logic              irq;
        logic              prev;
    } regs_st_t;

    regs_st_t q, d;
    logic     wr_ctrl, wr_filt, wr_safe, irq_set, irq_clr;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == REG_CTRL);
        wr_filt = wr_en && (wr_addr == REG_FILT);
        wr_safe = wr_en && (wr_addr == REG_SAFE);
        irq_clr = wr_en && (wr_addr == REG_STAT) && !wr_data[0];
        trip    = q.en && !flt;
        irq_set = (flt != q.prev) && (flt == q.pol);

        d      = q;
        d.prev = flt;
        if (wr_ctrl) begin
            d.dis = wr_data[NCH-1:0];
            d.en  = wr_data[DW-1];
        end
        if (trip) begin
            d.dis = '1;
        end
        if (wr_filt) begin
            d.fsel = wr_data[1:0];
            d.pol  = wr_data[2];
        end
        if (wr_safe) begin
            d.safe = wr_data[SAFE_W-1:0];
        end
        if (irq_clr) begin
            d.irq = 1'b0;
        end
        if (irq_set) begin
            d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{dis: '1, en: 1'b0, fsel: 2'b00, pol: 1'b0,
                   safe: '0, irq: 1'b0, prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CTRL: begin
                rd_data[NCH-1:0] = q.dis;
                rd_data[DW-1]    = q.en;
            end
            REG_FILT: rd_data[2:0] = {q.pol, q.fsel};
            REG_SAFE: rd_data[SAFE_W-1:0] = q.safe;
            default:  rd_data[0] = q.irq;
        endcase
    end

    assign dis  = q.dis;
    assign fsel = q.fsel;
    assign safe = q.safe;
    assign irq  = q.irq;

    // R3 / R6: a live trip leaves every disable bit set, whatever was written
    a_r3_trip_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (q.dis == '1));

    // R5 / R10: without a control write the bits only hold or go all-ones
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ((q.dis == $past(q.dis)) || (q.dis == '1)));

    // R9: set beats a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> q.irq);

    // R9: a raised flag stays until software clears it
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && !irq_clr) |=> q.irq);

endmodule

// File: rtl/pwm_trip_outmux.sv
module pwm_trip_outmux
    import pwm_trip_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]   pwm_in,
    input  logic [NCH-1:0]   dis,
    input  logic             trip,
    input  logic [2*NCH-1:0] safe,
    output logic [NCH-1:0]   pin_dat,
    output logic [NCH-1:0]   pin_oe
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic  blocked;
        safe_e code;

        always_comb begin
            blocked = dis[ch] || trip;
            code    = safe_e'(safe[2*ch +: 2]);
            if (!blocked) begin
                pin_dat[ch] = pwm_in[ch];
                pin_oe[ch]  = 1'b1;
            end else begin
                unique case (code)
                    SAFE_LOW: begin
                        pin_dat[ch] = 1'b0;
                        pin_oe[ch]  = 1'b1;
                    end
                    SAFE_HIGH: begin
                        pin_dat[ch] = 1'b1;
                        pin_oe[ch]  = 1'b1;
                    end
                    default: begin
                        pin_dat[ch] = 1'b0;
                        pin_oe[ch]  = 1'b0;
                    end
                endcase
            end
        end

        // R7: a released pad never carries data
        always_comb begin
            a_r7_float_quiet: assert (pin_oe[ch] || !pin_dat[ch]);
        end
    end
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import pwm_trip_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DW      = 8,
    parameter int PRE_W   = 5,
    parameter int DIV_MID = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pwm_in,
    input  logic              fault_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [NCH-1:0]    pin_dat,
    output logic [NCH-1:0]    pin_oe,
    output logic              irq
);
    logic             flt;
    logic [1:0]       fsel;
    logic [NCH-1:0]   dis;
    logic             trip;
    logic [2*NCH-1:0] safe;

    pwm_trip_filter #(.PRE_W(PRE_W), .DIV_MID(DIV_MID)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_n (fault_n),
        .fsel    (fsel),
        .flt_o   (flt)
    );

    pwm_trip_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .flt     (flt),
        .dis     (dis),
        .trip    (trip),
        .fsel    (fsel),
        .safe    (safe),
        .irq     (irq)
    );

    pwm_trip_outmux #(.NCH(NCH)) u_outmux (
        .pwm_in  (pwm_in),
        .dis     (dis),
        .trip    (trip),
        .safe    (safe),
        .pin_dat (pin_dat),
        .pin_oe  (pin_oe)
    );

    // R1: enabled channels with no trip pass the waveform straight through
    a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((dis == '0) && !trip) |-> ((pin_oe == '1) && (pin_dat == pwm_in)));

endmodule

// File: tb/pwm_trip_guard_tb.sv
module pwm_trip_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pwm_in = '0;
    logic       fault_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] pin_dat, pin_oe;
    logic       irq;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    pwm_trip_guard u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .fault_n(fault_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_dat(pin_dat), .pin_oe(pin_oe), .irq(irq)
    );

    // reference state built from the requirements
    logic       m_s1, m_s2, m_flt, m_en, m_pol, m_irq, m_prev;
    logic [1:0] m_hist, m_fsel;
    logic [4:0] m_cnt;
    logic [3:0] m_dis;
    logic [7:0] m_safe;

    function automatic logic m_live();
        return (m_fsel == 2'b00) ? m_s2 : m_flt;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_flt = 1; m_hist = 2'b11; m_cnt = 0;
            m_dis = 4'hF; m_en = 0; m_fsel = 0; m_pol = 0;
            m_safe = 0; m_irq = 0; m_prev = 1;
        end else begin
            logic lv, tk, nflt;
            logic [1:0] nh;
            lv = m_live();
            tk = (m_fsel == 2'd1) || (m_fsel == 2'd2 && m_cnt[2:0] == 3'd7) ||
                 (m_fsel == 2'd3 && m_cnt == 5'd31);
            nflt = m_flt; nh = m_hist;
            if (m_fsel == 2'd0) begin nflt = m_s2; nh = {m_s2, m_s2}; end
            else if (tk) begin
                nh = {m_hist[0], m_s2};
                if (m_s2 == m_hist[0] && m_s2 == m_hist[1]) nflt = m_s2;
            end
            if (wr_en && wr_addr == 2'd3 && !wr_data[0]) m_irq = 0;
            if (lv != m_prev && lv == m_pol) m_irq = 1;
            if (wr_en && wr_addr == 2'd0) m_dis = wr_data[3:0];
            if (m_en && !lv) m_dis = 4'hF;
            if (wr_en && wr_addr == 2'd0) m_en = wr_data[7];
            if (wr_en && wr_addr == 2'd1) begin m_fsel = wr_data[1:0]; m_pol = wr_data[2]; end
            if (wr_en && wr_addr == 2'd2) m_safe = wr_data;
            m_prev = lv; m_flt = nflt; m_hist = nh;
            m_s2 = m_s1; m_s1 = fault_n; m_cnt = m_cnt + 1;
        end
    end

    function automatic logic [7:0] exp_pins();
        logic [3:0] d, o;
        logic tr;
        tr = m_en && !m_live();
        for (int i = 0; i < 4; i++) begin
            if (!(m_dis[i] || tr)) begin d[i] = pwm_in[i]; o[i] = 1; end
            else begin
                d[i] = (m_safe[2*i +: 2] == 2'b10);
                o[i] = (m_safe[2*i +: 2] == 2'b01) || (m_safe[2*i +: 2] == 2'b10);
            end
        end
        return {o, d};
    endfunction

    function automatic logic [7:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return {m_en, 3'b000, m_dis};
            2'd1: return {5'b0, m_pol, m_fsel};
            2'd2: return m_safe;
            default: return {7'b0, m_irq};
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // advance one clock and compare against the reference
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R1 R7 pins vs model", {pin_oe, pin_dat}, exp_pins());
        chk("R9 irq vs model", irq, m_irq);
        chk("R2 readback vs model", rd_data, exp_rd(rd_addr));
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] dt);
        wr_en = 1; wr_addr = a; wr_data = dt;
        step();
        wr_en = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        pwm_in = 4'b1010;
        repeat (3) @(negedge clk);
        // reset state: all disabled, pads released
        rd_addr = 2'd0;
        #1;
        chk("R2 reset ctrl", rd_data, 8'h0F);
        chk("R7 reset pads released", {pin_oe, pin_dat}, 8'h00);
        chk("R9 reset irq", irq, 1'b0);
        rst_n = 1;
        step();

        // fallbacks: A float, B low, C high, D float (code 11)
        wr(2'd2, 8'b11_10_01_00);
        wr(2'd0, 8'h80);
        step();
        chk("R1 pass-through", {pin_oe, pin_dat}, {4'hF, pwm_in});

        // R4: bypassed filter, two-edge response
        fault_n = 0;
        step();
        chk("R4 still PWM after first edge", {pin_oe, pin_dat}, {4'hF, pwm_in});
        step();
        chk("R4 fallback after second edge", {pin_oe, pin_dat}, {4'b0110, 4'b0100});
        step();
        chk("R3 all disable bits set", rd_data, 8'h8F);
        chk("R9 falling edge raised irq", irq, 1'b1);

        // R6: clear attempt during the fault
        wr(2'd0, 8'h80);
        chk("R6 clear ignored while fault low", rd_data, 8'h8F);
        wr(2'd3, 8'h00);
        chk("R9 irq cleared by write", irq, 1'b0);

        // R5: sticky after release, then cleared
        fault_n = 1;
        repeat (4) step();
        chk("R5 bits stay set after release", rd_data, 8'h8F);
        wr(2'd0, 8'h80);
        chk("R5 write clears bits", rd_data, 8'h80);
        chk("R5 pads back to PWM", {pin_oe, pin_dat}, {4'hF, pwm_in});

        // R8: two-clock glitch rejected at the every-clock rate
        wr(2'd1, 8'h01);
        fault_n = 0; step(); step();
        fault_n = 1;
        repeat (6) step();
        chk("R8 short glitch rejected", rd_data, 8'h80);
        fault_n = 0;
        repeat (8) step();
        chk("R8 long low trips", rd_data, 8'h8F);
        fault_n = 1;
        repeat (8) step();

        // R10: disarmed, fault has no effect
        wr(2'd0, 8'h00);
        fault_n = 0;
        repeat (8) step();
        chk("R10 disarmed bits untouched", rd_data, 8'h00);
        chk("R10 disarmed pads PWM", {pin_oe, pin_dat}, {4'hF, pwm_in});
        fault_n = 1;
        repeat (4) step();

        // random phase against the reference
        for (int i = 0; i < 4000; i++) begin
            pwm_in = 4'($urandom);
            rd_addr = 2'($urandom);
            if ($urandom_range(0, 24) == 0) fault_n = ~fault_n;
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1; wr_addr = 2'($urandom); wr_data = 8'($urandom);
            end else begin
                wr_en = 0;
            end
            step();
        end
        wr_en = 0;
        finish_run();
    end
endmodule